// File: doc/BRIEF.md
# 8x8 Bit-Matrix Multiplier

This block reads each of two 64-bit operands as a square 8x8 matrix of bits and forms their boolean product. Each result element is the dot product of one row of the first matrix and one column of the second. A mode input picks how the eight partial products are combined: as a parity, which gives the product over GF(2), or as a logical OR, which gives the product over the boolean semiring. A third mode skips the product and returns the transpose of the first operand, so software gets matrix transposition from the same unit.

The unit is purely combinational. An execution pipeline places its operands on the inputs and captures `result` in its own register in the same cycle. Any staging or register-file plumbing belongs to the surrounding datapath.

Top module: `bitmat_mul8`

## Requirements
- R1: Matrix element (i, j) of any operand or of the result is bit 8*i + j. Row i is therefore byte i, and column j is made of bit j of each byte.
- R2: With op_mode = 1 (parity product), result bit 8*i + j is the XOR over r = 0..7 of (op_a[8*i + r] AND op_b[8*r + j]).
- R3: With op_mode = 2 (OR product), result bit 8*i + j is 1 exactly when op_a[8*i + r] AND op_b[8*r + j] holds for at least one r in 0..7.
- R4: With op_mode = 0 (transpose), result bit 8*r + c equals op_a bit 8*c + r, and op_b has no effect on the result.
- R5: With op_mode = 3 (reserved), the result is all zeros whatever the operands are.
- R6: In both product modes, an operand equal to the identity 0x8040201008040201 on either side returns the other operand unchanged.
- R7: In both product modes, an all-zero op_a yields an all-zero result.
- R8: For the same operands, every bit set in the parity product is also set in the OR product.
- R9: The result depends only on the present inputs and has no internal state. It is valid one short settling time after any input changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 64 | First matrix (left factor, or the matrix to transpose) |
| op_b | input | 64 | Second matrix (right factor) |
| op_mode | input | 2 | 0 transpose, 1 parity product, 2 OR product, 3 reserved |
| result | output | 64 | Product or transpose |

## Verification
Every pair of single-bit operands is applied in both product modes. A lone set bit in each matrix isolates one row-column pairing, so this sweep exposes any misplaced row, column or transpose index. Single-bit first operands also map every transpose position, and in that sweep op_b is driven with random values to show it has no effect. Random dense operands in all four modes exercise the parity and OR sums, where even and odd overlap counts separate the two. Identity multiplication, zero operands and the reserved code are checked on their own as fixed algebraic corner cases.

// File: rtl/bmm_pkg.sv
// Package: shared types and constants for the bit-matrix multiplier.
// Assumes square matrices packed row-major, one row per DIM-bit slice.
package bmm_pkg;

    // Default matrix dimension (rows = columns).
    localparam int BMM_DIM = 8;

    // Operation selector; codes are part of the block's interface.
    typedef enum logic [1:0] {
        BMM_OP_TRANSPOSE = 2'd0,
        BMM_OP_PARITY    = 2'd1,
        BMM_OP_ANY       = 2'd2,
        BMM_OP_RESERVED  = 2'd3
    } bmm_op_e;

endpackage

// File: rtl/bmm_transpose.sv
// Module: bmm_transpose
// Swaps rows and columns of a DIM x DIM bit matrix packed row-major
// (element (r, c) at bit r*DIM + c). Pure wiring, no logic depth.
module bmm_transpose #(
    parameter int DIM = bmm_pkg::BMM_DIM,
    localparam int W  = DIM * DIM
) (
    input  logic [W-1:0] mat_i,
    output logic [W-1:0] mat_o
);

    // Route element (c, r) of the input to element (r, c) of the output.
    for (genvar r = 0; r < DIM; r++) begin : g_row
        for (genvar c = 0; c < DIM; c++) begin : g_col
            assign mat_o[r*DIM + c] = mat_i[c*DIM + r];
        end
    end

    // Transposition permutes bits: population and diagonal are kept.
    always_comb begin
        AST_TRANSPOSE_POPCOUNT: assert ($countones(mat_o) == $countones(mat_i))
            else $error("transpose changed population count"); // R4
        for (int d = 0; d < DIM; d++) begin
            AST_TRANSPOSE_DIAGONAL: assert (mat_o[d*DIM + d] == mat_i[d*DIM + d])
                else $error("transpose moved a diagonal element"); // R4
        end
    end

endmodule

// File: rtl/bmm_dot_cell.sv
// Module: bmm_dot_cell
// Forms one result element: ANDs a row with a column, then reduces
// the DIM partial products both as parity and as any-set.
// Assumes both vectors are ordered by the same inner index r.
module bmm_dot_cell #(
    parameter int DIM = bmm_pkg::BMM_DIM
) (
    input  logic [DIM-1:0] row_i,
    input  logic [DIM-1:0] col_i,
    output logic           par_o,
    output logic           any_o
);

    logic [DIM-1:0] partial;

    // Partial products shared by both reductions.
    assign partial = row_i & col_i;

    // Parity sum (GF(2)) and OR sum (boolean semiring).
    assign par_o = ^partial;
    assign any_o = |partial;

endmodule

// File: rtl/bmm_matmul.sv
// Module: bmm_matmul
// Computes both the parity product and the OR product of two DIM x DIM
// bit matrices. The right factor is transposed once so that each
// column becomes a contiguous slice; one dot cell per element.
module bmm_matmul #(
    parameter int DIM = bmm_pkg::BMM_DIM,
    localparam int W  = DIM * DIM
) (
    input  logic [W-1:0] lhs_i,
    input  logic [W-1:0] rhs_i,
    output logic [W-1:0] par_prod_o,
    output logic [W-1:0] any_prod_o
);

    logic [W-1:0] rhs_cols;

    // Columns of the right factor as contiguous rows.
    bmm_transpose #(.DIM(DIM)) u_rhs_t (
        .mat_i (rhs_i),
        .mat_o (rhs_cols)
    );

    // One dot cell per output element (i, j).
    for (genvar i = 0; i < DIM; i++) begin : g_i
        for (genvar j = 0; j < DIM; j++) begin : g_j
            bmm_dot_cell #(.DIM(DIM)) u_cell (
                .row_i (lhs_i[i*DIM +: DIM]),
                .col_i (rhs_cols[j*DIM +: DIM]),
                .par_o (par_prod_o[i*DIM + j]),
                .any_o (any_prod_o[i*DIM + j])
            );
        end
    end

    // Odd overlap implies non-empty overlap; empty left factor kills both.
    always_comb begin
        AST_PARITY_WITHIN_ANY: assert ((par_prod_o & ~any_prod_o) == '0)
            else $error("parity bit set where OR product is clear"); // R8
        if (lhs_i == '0) begin
            AST_ZERO_LHS_ANY: assert (any_prod_o == '0)
                else $error("zero left factor gave nonzero product"); // R7
        end
    end

endmodule

// File: rtl/bitmat_mul8.sv
// Module: bitmat_mul8 (top)
// Bit-matrix unit: selects between transpose of op_a, the parity
// product, the OR product, or zero for the reserved code.
// Fully combinational; the caller registers the result.
module bitmat_mul8 #(
    parameter int DIM = bmm_pkg::BMM_DIM,
    localparam int W  = DIM * DIM
) (
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    input  logic [1:0]   op_mode,
    output logic [W-1:0] result
);
    import bmm_pkg::*;

    bmm_op_e      mode_sel;
    logic [W-1:0] a_trans;
    logic [W-1:0] par_prod;
    logic [W-1:0] any_prod;

    // Decode the raw mode code into the operation type.
    assign mode_sel = bmm_op_e'(op_mode);

    // Standalone transpose of the first operand.
    bmm_transpose #(.DIM(DIM)) u_a_t (
        .mat_i (op_a),
        .mat_o (a_trans)
    );

    // Both products from a shared AND array.
    bmm_matmul #(.DIM(DIM)) u_mm (
        .lhs_i      (op_a),
        .rhs_i      (op_b),
        .par_prod_o (par_prod),
        .any_prod_o (any_prod)
    );

    // Output selection by mode.
    always_comb begin
        unique case (mode_sel)
            BMM_OP_TRANSPOSE: result = a_trans;
            BMM_OP_PARITY:    result = par_prod;
            BMM_OP_ANY:       result = any_prod;
            default:          result = '0;
        endcase
    end

    // Port-level relations per mode.
    always_comb begin
        if (op_mode == 2'd3) begin
            AST_RESERVED_ZERO: assert (result == '0)
                else $error("reserved mode produced nonzero"); // R5
        end
        if (op_mode == 2'd0) begin
            AST_TRANSPOSE_WEIGHT: assert ($countones(result) == $countones(op_a))
                else $error("transpose result weight differs from op_a"); // R4
        end
        if ((op_mode == 2'd1 || op_mode == 2'd2) && (op_a == '0 || op_b == '0)) begin
            AST_ZERO_FACTOR: assert (result == '0)
                else $error("zero factor gave nonzero product"); // R7
        end
    end

endmodule

// File: tb/bitmat_mul8_tb_top.sv
// Bench for bitmat_mul8: exhaustive single-bit sweeps, identity,
// zero and random dense operands against an arithmetic model.
module bitmat_mul8_tb_top;

    localparam int N = 8;
    localparam int W = N * N;
    localparam logic [W-1:0] IDENT = 64'h8040201008040201;

    logic         clk = 1'b0;
    logic [W-1:0] op_a = '0;
    logic [W-1:0] op_b = '0;
    logic [1:0]   op_mode = 2'd0;
    logic [W-1:0] result;
    int           n_cmp = 0;
    int           n_bad = 0;
    bit           done = 1'b0;

    always #2.5 clk = ~clk;

    bitmat_mul8 dut_i (
        .op_a    (op_a),
        .op_b    (op_b),
        .op_mode (op_mode),
        .result  (result)
    );

    // Model built from R1..R5 element formulas.
    function automatic logic [W-1:0] model(input logic [1:0] m,
                                           input logic [W-1:0] a,
                                           input logic [W-1:0] b);
        logic [W-1:0] r = '0;
        for (int i = 0; i < N; i++) begin
            for (int j = 0; j < N; j++) begin
                int cnt = 0;
                for (int k = 0; k < N; k++) cnt += int'(a[i*N+k] & b[k*N+j]);
                case (m)
                    2'd0: r[i*N+j] = a[j*N+i];
                    2'd1: r[i*N+j] = cnt[0];
                    2'd2: r[i*N+j] = (cnt != 0);
                    default: r[i*N+j] = 1'b0;
                endcase
            end
        end
        return r;
    endfunction

    // Drive at the falling edge, compare 1 ns later (R9: no clock needed).
    task automatic apply(input logic [1:0] m, input logic [W-1:0] a,
                         input logic [W-1:0] b, input logic [W-1:0] exp,
                         input string req);
        @(negedge clk);
        op_mode = m; op_a = a; op_b = b;
        #1;
        n_cmp++;
        if (result !== exp) begin
            n_bad++;
            $display("FAIL %s mode=%0d a=%h b=%h got=%h exp=%h",
                     req, m, a, b, result, exp);
        end
    endtask

    function automatic logic [W-1:0] rnd64();
        return {$urandom(), $urandom()};
    endfunction

    initial begin
        logic [W-1:0] x, y;
        // R9 / R7: all-zero inputs in every mode give zero.
        for (int m = 0; m < 4; m++) apply(2'(m), '0, '0, '0, "R9");

        // R1 R2 R3: every single-bit pair in both product modes.
        for (int p = 0; p < W; p++) begin
            for (int q = 0; q < W; q++) begin
                x = W'(1) << p; y = W'(1) << q;
                apply(2'd1, x, y, model(2'd1, x, y), "R2");
                apply(2'd2, x, y, model(2'd2, x, y), "R3");
            end
        end

        // R4: each single bit of op_a lands at its transposed place; op_b random.
        for (int p = 0; p < W; p++) begin
            x = '0;
            x[(p % N)*N + p / N] = 1'b1;
            apply(2'd0, W'(1) << p, rnd64(), x, "R4");
        end

        // R6: identity on either side, both product modes.
        for (int t = 0; t < 200; t++) begin
            x = rnd64();
            apply(2'd1, IDENT, x, x, "R6");
            apply(2'd1, x, IDENT, x, "R6");
            apply(2'd2, IDENT, x, x, "R6");
            apply(2'd2, x, IDENT, x, "R6");
        end

        // R7: zero left factor; R5: reserved code with dense operands.
        for (int t = 0; t < 100; t++) begin
            y = rnd64();
            apply(2'd1, '0, y, '0, "R7");
            apply(2'd2, '0, y, '0, "R7");
            apply(2'd3, rnd64(), y, '0, "R5");
            apply(2'd3, '1, '1, '0, "R5");
        end

        // R2 R3 R4 R8: random dense operands in all modes.
        for (int t = 0; t < 2000; t++) begin
            logic [W-1:0] pp, ap;
            x = rnd64(); y = rnd64();
            if (t % 3 == 0) x = x & rnd64();
            apply(2'd0, x, y, model(2'd0, x, y), "R4");
            apply(2'd1, x, y, model(2'd1, x, y), "R2");
            pp = result;
            apply(2'd2, x, y, model(2'd2, x, y), "R3");
            ap = result;
            n_cmp++;
            if ((pp & ~ap) != '0) begin
                n_bad++;
                $display("FAIL R8 parity=%h or=%h exp=%h", pp, ap, W'(0));
            end
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog got=timeout exp=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule